// File: doc/BRIEF.md
# Configurable Macrocell Register

This block is one output cell of a programmable logic array. Its configuration bits arrive as static inputs, and its data input is a sum-of-products term computed upstream. The cell can store that term in a flip-flop that acts as either a D-type or a toggle-type element, or it can pass the term straight to the output with no register.

The flip-flop is clocked by one of several clock sources, and each cell picks the active edge of that clock. Two shared control terms give an asynchronous preset and an asynchronous clear. Each of these can be switched off for the cell, and the clear wins whenever both are active.

The output-enable comes from one of the shared enable terms, or it can be fixed on or fixed off. An active-low global tri-state pin overrides the enable when that pin is armed. The cell returns two feedback signals to the routing fabric:

- the value presented to the output buffer;
- the value seen at the pin, which is the external input whenever the buffer is off.

Top module: `mcell_top`

## Requirements
- R1: While `rst_n` is low the register holds 0, so in registered mode `pad_out` reads 0.
- R2: With `cfg_toggle`=0 the register loads `sop_in` on each active edge of the selected clock.
- R3: With `cfg_toggle`=1 the register inverts on an active edge when `sop_in` is 1 and keeps its value when `sop_in` is 0.
- R4: `cfg_clk_sel` (binary index) picks which bit of `clk_src` clocks the register; edges on the other bits have no effect.
- R5: `cfg_clk_fall`=1 makes the falling edge of the selected clock the active edge; 0 selects the rising edge.
- R6: With `cfg_preset_en`=1, a high `ct_preset` forces the register to 1 at once, with no clock needed; with `cfg_preset_en`=0, `ct_preset` is ignored.
- R7: With `cfg_reset_en`=1, a high `ct_reset` forces the register to 0 at once; it takes priority over an active preset; with `cfg_reset_en`=0, `ct_reset` is ignored.
- R8: The `cfg_oe_sel` code sets `pad_oe`, subject to R9:
  - 0: `pad_oe` is 0;
  - 1: `pad_oe` is 1;
  - 2 or 3: `pad_oe` is 0;
  - 4 to 7: `pad_oe` follows `ct_oe[code-4]`.
- R9: When `cfg_gts_en`=1 and `gts_n`=0, `pad_oe` is 0 whatever the code; when `cfg_gts_en`=0, `gts_n` is ignored.
- R10: With `cfg_comb`=1, `pad_out` equals `sop_in` combinationally and the register is not seen at the output.
- R11: `fb_cell` always equals `pad_out`; `fb_pin` equals `pad_out` when `pad_oe` is 1 and `pin_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 4 | Candidate clocks; bit 0 is the pin clock, the others may come from logic |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sop_in | input | 1 | Sum-of-products data term |
| ct_preset | input | 1 | Shared asynchronous preset term |
| ct_reset | input | 1 | Shared asynchronous clear term |
| ct_oe | input | 4 | Shared output-enable terms |
| gts_n | input | 1 | Global tri-state pin, active low |
| pin_in | input | 1 | Level seen on the pad from outside |
| cfg_clk_sel | input | 2 | Clock source index |
| cfg_clk_fall | input | 1 | 1 selects falling-edge clocking |
| cfg_toggle | input | 1 | 1 selects toggle mode, 0 selects D mode |
| cfg_preset_en | input | 1 | Arms the preset term |
| cfg_reset_en | input | 1 | Arms the clear term |
| cfg_oe_sel | input | 3 | Output-enable source code |
| cfg_gts_en | input | 1 | Arms the global tri-state pin |
| cfg_comb | input | 1 | Bypasses the register |
| pad_out | output | 1 | Data toward the output buffer |
| pad_oe | output | 1 | Output buffer enable |
| fb_cell | output | 1 | Feedback taken before the buffer |
| fb_pin | output | 1 | Feedback taken after the buffer |

## Verification
The hardest case is an asynchronous term that changes between edges of a clock that is not the bench clock. The case is harder still when that clock is a slow source or uses the falling edge.

The bench drives each clock source as one bit of a free-running counter, so each source runs at a different rate. It changes the control terms only at mid-cycle, away from every source edge, and it changes the configuration only while reset is held.

Random preset and clear pulses therefore land before, between and after active edges. The bench never releases the clear while the preset is still held, so the expected state stays well defined. Each configuration phase weights the async terms differently, so both the clear-beats-preset case and long runs of clean data capture occur.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    localparam int CLK_COUNT = 4;
    localparam int OE_TERMS  = 4;

    localparam int CLK_SEL_W = $clog2(CLK_COUNT);
    localparam int OE_IDX_W  = $clog2(OE_TERMS);
    localparam int OE_MODE_W = OE_IDX_W + 1;

    localparam logic [OE_MODE_W-1:0] OE_FIXED_OFF = '0;
    localparam logic [OE_MODE_W-1:0] OE_FIXED_ON  = OE_MODE_W'(1);

    typedef struct packed {
        logic bit_val;
    } cell_state_t;

endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
    parameter int NUM_CLK = mcell_pkg::CLK_COUNT,
    localparam int SEL_W  = $clog2(NUM_CLK)
) (
    input  logic [NUM_CLK-1:0] clk_src,
    input  logic [SEL_W-1:0]   sel,
    input  logic               fall,
    output logic               eff_clk
);

    logic [NUM_CLK-1:0] hit;

    generate
        for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_pick
            assign hit[gi] = (sel == SEL_W'(gi)) & clk_src[gi];
        end
    endgenerate

    // Inverting the chosen clock turns its falling edge into a rising one.
    assign eff_clk = (|hit) ^ fall;

endmodule

// File: rtl/mcell_ff.sv
module mcell_ff (
    input  logic eff_clk,
    input  logic rst_n,
    input  logic d_in,
    input  logic toggle,
    input  logic set_req,
    input  logic set_en,
    input  logic clr_req,
    input  logic clr_en,
    output logic q_o
);
    import mcell_pkg::*;

    logic        set_act;
    logic        clr_act;
    cell_state_t st_d;
    cell_state_t st_q;

    assign set_act = set_req & set_en;
    assign clr_act = clr_req & clr_en;

    always_comb begin
        st_d = st_q;
        if (toggle) begin
            st_d.bit_val = st_q.bit_val ^ d_in;
        end else begin
            st_d.bit_val = d_in;
        end
    end

    // Priority: power-on reset, then clear, then preset, then clocked load.
    always_ff @(posedge eff_clk or negedge rst_n or posedge clr_act or posedge set_act) begin
        if (!rst_n) begin
            st_q.bit_val <= 1'b0;
        end else if (clr_act) begin
            st_q.bit_val <= 1'b0;
        end else if (set_act) begin
            st_q.bit_val <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.bit_val;

    AST_CLEAR_WINS: assert property (@(posedge eff_clk) disable iff (!rst_n)
        (clr_act && $past(clr_act)) |-> (q_o == 1'b0))
        else $error("clear held but register not zero"); // R7

    AST_PRESET_HOLDS: assert property (@(posedge eff_clk) disable iff (!rst_n)
        (set_act && !clr_act && $past(set_act && !clr_act) && $past(rst_n)) |-> (q_o == 1'b1))
        else $error("preset held but register not one"); // R6

endmodule

// File: rtl/mcell_oe.sv
module mcell_oe #(
    parameter int NUM_OE   = mcell_pkg::OE_TERMS,
    localparam int IDX_W   = $clog2(NUM_OE),
    localparam int MODE_W  = IDX_W + 1
) (
    input  logic [NUM_OE-1:0] ct_oe,
    input  logic [MODE_W-1:0] mode,
    input  logic              gts_en,
    input  logic              gts_n,
    output logic              oe
);

    logic [NUM_OE-1:0] term_hit;
    logic              local_oe;
    logic              global_off;

    generate
        for (genvar gi = 0; gi < NUM_OE; gi++) begin : g_term
            assign term_hit[gi] = mode[MODE_W-1] &
                                  (mode[IDX_W-1:0] == IDX_W'(gi)) & ct_oe[gi];
        end
    endgenerate

    always_comb begin
        if (mode[MODE_W-1]) begin
            local_oe = |term_hit;
        end else begin
            local_oe = (mode == MODE_W'(1));
        end
    end

    assign global_off = gts_en & ~gts_n;
    assign oe         = local_oe & ~global_off;

endmodule

// File: rtl/mcell_top.sv
module mcell_top #(
    parameter int CLK_N  = mcell_pkg::CLK_COUNT,
    parameter int OE_N   = mcell_pkg::OE_TERMS,
    localparam int SEL_W = $clog2(CLK_N),
    localparam int OEM_W = $clog2(OE_N) + 1
) (
    input  logic [CLK_N-1:0] clk_src,
    input  logic             rst_n,
    input  logic             sop_in,
    input  logic             ct_preset,
    input  logic             ct_reset,
    input  logic [OE_N-1:0]  ct_oe,
    input  logic             gts_n,
    input  logic             pin_in,
    input  logic [SEL_W-1:0] cfg_clk_sel,
    input  logic             cfg_clk_fall,
    input  logic             cfg_toggle,
    input  logic             cfg_preset_en,
    input  logic             cfg_reset_en,
    input  logic [OEM_W-1:0] cfg_oe_sel,
    input  logic             cfg_gts_en,
    input  logic             cfg_comb,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             fb_cell,
    output logic             fb_pin
);

    logic eff_clk;
    logic reg_q;
    logic cell_val;
    logic oe_int;

    mcell_clk_sel #(.NUM_CLK(CLK_N)) u_clk (
        .clk_src (clk_src),
        .sel     (cfg_clk_sel),
        .fall    (cfg_clk_fall),
        .eff_clk (eff_clk)
    );

    mcell_ff u_ff (
        .eff_clk (eff_clk),
        .rst_n   (rst_n),
        .d_in    (sop_in),
        .toggle  (cfg_toggle),
        .set_req (ct_preset),
        .set_en  (cfg_preset_en),
        .clr_req (ct_reset),
        .clr_en  (cfg_reset_en),
        .q_o     (reg_q)
    );

    mcell_oe #(.NUM_OE(OE_N)) u_oe (
        .ct_oe  (ct_oe),
        .mode   (cfg_oe_sel),
        .gts_en (cfg_gts_en),
        .gts_n  (gts_n),
        .oe     (oe_int)
    );

    always_comb begin
        cell_val = cfg_comb ? sop_in : reg_q;
    end

    assign pad_out = cell_val;
    assign fb_cell = cell_val;
    assign pad_oe  = oe_int;
    assign fb_pin  = oe_int ? cell_val : pin_in;

    AST_GTS_FORCES_OFF: assert property (@(posedge eff_clk) disable iff (!rst_n)
        (cfg_gts_en && !gts_n) |-> !pad_oe)
        else $error("global tri-state ignored"); // R9

    AST_OE_FIXED_OFF: assert property (@(posedge eff_clk) disable iff (!rst_n)
        (cfg_oe_sel == mcell_pkg::OE_FIXED_OFF) |-> !pad_oe)
        else $error("fixed-off enable driven"); // R8

    AST_BYPASS_PATH: assert property (@(posedge eff_clk) disable iff (!rst_n)
        cfg_comb |-> (pad_out == sop_in))
        else $error("bypass not transparent"); // R10

    AST_PIN_FEEDBACK: assert property (@(posedge eff_clk) disable iff (!rst_n)
        pad_oe |-> (fb_pin == pad_out))
        else $error("pin feedback differs from driven value"); // R11

endmodule

// File: tb/mcell_top_tb_top.sv
module mcell_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       tb_clk = 1'b0;
    logic [3:0] clk_src = 4'd0;
    logic       rst_n = 1'b0;
    logic       sop_in = 1'b0;
    logic       ct_preset = 1'b0;
    logic       ct_reset = 1'b0;
    logic [3:0] ct_oe = 4'd0;
    logic       gts_n = 1'b1;
    logic       pin_in = 1'b0;
    logic [1:0] cfg_clk_sel = 2'd0;
    logic       cfg_clk_fall = 1'b0;
    logic       cfg_toggle = 1'b0;
    logic       cfg_preset_en = 1'b0;
    logic       cfg_reset_en = 1'b0;
    logic [2:0] cfg_oe_sel = 3'd0;
    logic       cfg_gts_en = 1'b0;
    logic       cfg_comb = 1'b0;
    logic       pad_out, pad_oe, fb_cell, fb_pin;

    int total = 0;
    int bad   = 0;
    bit m_q   = 1'b0;

    always #(CLK_PERIOD/2) tb_clk = ~tb_clk;

    mcell_top dut_i (
        .clk_src(clk_src), .rst_n(rst_n), .sop_in(sop_in),
        .ct_preset(ct_preset), .ct_reset(ct_reset), .ct_oe(ct_oe),
        .gts_n(gts_n), .pin_in(pin_in), .cfg_clk_sel(cfg_clk_sel),
        .cfg_clk_fall(cfg_clk_fall), .cfg_toggle(cfg_toggle),
        .cfg_preset_en(cfg_preset_en), .cfg_reset_en(cfg_reset_en),
        .cfg_oe_sel(cfg_oe_sel), .cfg_gts_en(cfg_gts_en), .cfg_comb(cfg_comb),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_cell(fb_cell), .fb_pin(fb_pin)
    );

    function automatic bit lvl(input logic [3:0] c);
        return c[cfg_clk_sel] ^ cfg_clk_fall;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        logic e_out, e_oe, e_pin;
        e_out = cfg_comb ? sop_in : m_q;
        if (cfg_gts_en && !gts_n) e_oe = 1'b0;
        else if (cfg_oe_sel[2]) e_oe = ct_oe[cfg_oe_sel[1:0]];
        else e_oe = (cfg_oe_sel == 3'd1);
        e_pin = e_oe ? e_out : pin_in;
        check(tag, "pad_out", pad_out, e_out);
        check(tag, "pad_oe", pad_oe, e_oe);
        check("R11", "fb_cell", fb_cell, e_out);
        check("R11", "fb_pin", fb_pin, e_pin);
    endtask

    // Each clock source is one bit of a counter stepped on tb_clk rising edges.
    task automatic step_clocks();
        bit old_l;
        bit clr_e, set_e;
        @(posedge tb_clk);
        old_l = lvl(clk_src);
        clk_src = clk_src + 4'd1;
        clr_e = ct_reset & cfg_reset_en;
        set_e = ct_preset & cfg_preset_en;
        if (!old_l && lvl(clk_src) && rst_n) begin
            if (clr_e) m_q = 1'b0;
            else if (set_e) m_q = 1'b1;
            else m_q = cfg_toggle ? (m_q ^ sop_in) : sop_in;
        end
    endtask

    task automatic run_phase(input string tag, input logic [1:0] sel, input logic fall,
                             input logic tog, input logic pen, input logic ren,
                             input logic [2:0] oe, input logic gen, input logic comb,
                             input int async_w, input int cycles);
        @(negedge tb_clk);
        rst_n = 1'b0; ct_preset = 1'b0; ct_reset = 1'b0; sop_in = 1'b0;
        m_q = 1'b0;
        cfg_clk_sel = sel; cfg_clk_fall = fall; cfg_toggle = tog;
        cfg_preset_en = pen; cfg_reset_en = ren; cfg_oe_sel = oe;
        cfg_gts_en = gen; cfg_comb = comb;
        for (int k = 0; k < 3; k++) begin
            step_clocks();
            #(CLK_PERIOD/4);
            if (!comb) check("R1", "pad_out in reset", pad_out, 1'b0);
        end
        @(negedge tb_clk);
        rst_n = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            logic np, nr, old_clr;
            @(negedge tb_clk);
            old_clr = ct_reset & cfg_reset_en;
            np = (($urandom % 16) < async_w);
            nr = (($urandom % 16) < async_w);
            if (old_clr && !(nr & cfg_reset_en) && (np & cfg_preset_en)) np = 1'b0;
            ct_preset = np; ct_reset = nr;
            sop_in = 1'($urandom); ct_oe = 4'($urandom);
            gts_n = 1'($urandom); pin_in = 1'($urandom);
            if (ct_reset & cfg_reset_en) m_q = 1'b0;
            else if (ct_preset & cfg_preset_en) m_q = 1'b1;
            #1;
            compare(tag);
            step_clocks();
            #(CLK_PERIOD/4);
            compare(tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // tag, sel, fall, toggle, pen, ren, oe, gts_en, comb, async weight, cycles
        run_phase("R2",  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 0, 80);
        run_phase("R3",  2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 0, 80);
        run_phase("R4",  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 0, 80);
        run_phase("R4",  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 0, 80);
        run_phase("R5",  2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 0, 80);
        run_phase("R5",  2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 0, 80);
        run_phase("R6",  2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 4, 80);
        run_phase("R6",  2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 4, 80);
        run_phase("R7",  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 4, 80);
        run_phase("R7",  2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 8, 80);
        for (int m = 0; m < 8; m++)
            run_phase("R8", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'(m), 1'b0, 1'b0, 0, 24);
        run_phase("R9",  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 0, 60);
        run_phase("R9",  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 0, 60);
        run_phase("R10", 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 4, 60);
        run_phase("R11", 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b0, 2, 60);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule